// File: doc/BRIEF.md
# Synchronous presettable BCD decade counter

A single decimal digit counter holding a 4-bit value in 8421 BCD. On each rising clock edge it clears, loads a data word, advances by one, or holds. The choice follows a fixed priority: clear first, then load, then count, then hold. After 9 the next count returns to 0. Every change of the count output happens at a rising clock edge. The only exception is the chip-level reset input, which is asserted asynchronously and released through a synchroniser.

Two count enables decide whether the digit advances, and both must be high. The trickle enable also qualifies the terminal-count flag, which is high while the digit shows 9. This flag can drive the trickle enable of the next digit. Several digits can then share one clock and form a multi-digit decimal counter with no ripple clocking. The load path accepts any 4-bit word, including the six codes above 9. A fixed next-state map returns these codes to a legal digit within two count clocks, so the counter cannot lock up.

Top module: `bcd_decade_counter`

## Requirements
- R1: While `arst_n` is low, `q` is 0 without waiting for a clock edge. After `arst_n` rises, `q` holds 0 across the first two rising edges. From the third edge on, the counter follows the synchronous modes.
- R2: When `clr_n` is low at a rising edge, `q` becomes 0, whatever the values of `ld_n`, `en_p`, `en_t` and `din`.
- R3: When `clr_n` is high and `ld_n` is low at a rising edge, `q` takes the value of `din`. This holds for all 16 codes and whatever the enables are.
- R4: When `clr_n` and `ld_n` are high and both `en_p` and `en_t` are high, a legal digit advances by one at the edge: 0→1 … 8→9, and 9→0.
- R5: When `clr_n` and `ld_n` are high and either enable is low, `q` keeps its value at the edge. This includes the out-of-range codes.
- R6: `tc` is high exactly when `en_t` is high and `q` equals 9 (binary 1001). `en_p`, `ld_n`, `clr_n` and `din` do not change it.
- R7: When counting from an out-of-range code, the next value is fixed: 10→11, 12→13 and 14→15, while 11, 13 and 15 each go to 4.
- R8: From any out-of-range code, at most two counting edges bring `q` back to a value of 9 or below.
- R9: Two digits form a decimal pair when the low digit's `tc` drives the high digit's `en_t` and both `en_p` inputs are held high. The pair then runs 00 to 99 and wraps to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Chip reset, asynchronous assert, active low |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | 4 | Word loaded when `ld_n` is low |
| en_p | input | 1 | Count enable that gates counting only |
| en_t | input | 1 | Count enable that also gates `tc` |
| q | output | 4 | Current digit |
| tc | output | 1 | Terminal count, active high |

## Verification
A sweep forces each of the 16 codes into the digit. It then applies each of the 16 combinations of clear, load and the two enables, with a data word that varies from step to step. Each resulting value is compared against an arithmetic model. This separates the priority order (clear over load over count), the split enables (hold versus advance), the wrap at 9 and the recovery map above 9. In the same sweep, `tc` is sampled before each edge, which shows that only the trickle enable gates it. Further runs cover the reset release, the two-step recovery from each illegal code, and a two-digit cascade over more than a full 00 to 99 cycle.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int unsigned DIGIT_W = 4;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2,
    MODE_CLEAR = 2'd3
  } ctr_mode_e;
endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/bcd_mode_dec.sv
module bcd_mode_dec
  import bcd_ctr_pkg::*;
(
  input  logic      clr_n,
  input  logic      ld_n,
  input  logic      en_p,
  input  logic      en_t,
  output ctr_mode_e mode
);
  always_comb begin
    if (!clr_n)            mode = MODE_CLEAR;
    else if (!ld_n)        mode = MODE_LOAD;
    else if (en_p && en_t) mode = MODE_COUNT;
    else                   mode = MODE_HOLD;
  end
endmodule

// File: rtl/bcd_step.sv
module bcd_step #(
  parameter int unsigned W       = 4,
  parameter int unsigned LAST    = 9,
  parameter int unsigned RECOVER = 4
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] LAST_C    = W'(LAST);
  localparam logic [W-1:0] RECOVER_C = W'(RECOVER);

  always_comb begin
    if (cur == LAST_C)      nxt = '0;
    else if (cur < LAST_C)  nxt = cur + 1'b1;
    else if (!cur[0])       nxt = cur + 1'b1;
    else                    nxt = RECOVER_C;
  end
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
  import bcd_ctr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LAST_DIGIT  = 9,
  parameter int unsigned RECOVER_VAL = 4
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic [DIGIT_W-1:0] din,
  input  logic               en_p,
  input  logic               en_t,
  output logic [DIGIT_W-1:0] q,
  output logic               tc
);
  localparam logic [DIGIT_W-1:0] LAST_C = DIGIT_W'(LAST_DIGIT);

  logic               rst_n;
  ctr_mode_e          mode;
  logic [DIGIT_W-1:0] step_val;
  logic [DIGIT_W-1:0] q_nxt;
  logic               q_en;
  logic [DIGIT_W-1:0] q_r;

  bcd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n)
  );

  bcd_mode_dec u_dec (
    .clr_n (clr_n),
    .ld_n  (ld_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .mode  (mode)
  );

  bcd_step #(.W(DIGIT_W), .LAST(LAST_DIGIT), .RECOVER(RECOVER_VAL)) u_step (
    .cur (q_r),
    .nxt (step_val)
  );

  // next-state selection
  always_comb begin
    q_en = (mode != MODE_HOLD);
    case (mode)
      MODE_CLEAR: q_nxt = '0;
      MODE_LOAD:  q_nxt = din;
      MODE_COUNT: q_nxt = step_val;
      default:    q_nxt = q_r;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q  = q_r;
  assign tc = en_t && (q_r == LAST_C);

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0));
  // R3
  load_takes_din_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !ld_n) |=> (q == $past(din)));
  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && en_p && en_t && q == LAST_C) |=> (q == '0));
  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && en_p && en_t && q < LAST_C) |=> (q == $past(q) + 1'b1));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q));
  // R8
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && ld_n && en_p && en_t && q > LAST_C) |=> (q <= LAST_C || q == $past(q) + 1'b1));
  // R6
  tc_cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && en_p && clr_n && ld_n) |=> (q == '0));
endmodule

// File: tb/tb_bcd_decade_counter.sv
module tb_bcd_decade_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       clr_n, ld_n, en_p, en_t;
  logic [3:0] din;
  logic [3:0] q;
  logic       tc;

  logic       c_clr_n, c_en;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_decade_counter dut (
    .clk(clk), .arst_n(arst_n), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q), .tc(tc)
  );

  bcd_decade_counter lo (
    .clk(clk), .arst_n(arst_n), .clr_n(c_clr_n), .ld_n(1'b1), .din(4'd0),
    .en_p(c_en), .en_t(c_en), .q(lo_q), .tc(lo_tc)
  );

  bcd_decade_counter hi (
    .clk(clk), .arst_n(arst_n), .clr_n(c_clr_n), .ld_n(1'b1), .din(4'd0),
    .en_p(c_en), .en_t(lo_tc), .q(hi_q), .tc(hi_tc)
  );

  function automatic logic [3:0] model_inc(input logic [3:0] s);
    int v = int'(s);
    if (v == 9)          return 4'd0;
    else if (v < 9)      return 4'(v + 1);
    else if (v % 2 == 0) return 4'(v + 1);
    else                 return 4'd4;
  endfunction

  function automatic logic [3:0] model_next(input logic [3:0] s, input logic c,
      input logic l, input logic [3:0] d, input logic p, input logic t);
    if (!c)          return 4'd0;
    else if (!l)     return d;
    else if (p && t) return model_inc(s);
    else             return s;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic c, input logic l, input logic [3:0] d,
                     input logic p, input logic t);
    @(negedge clk);
    clr_n = c; ld_n = l; din = d; en_p = p; en_t = t;
  endtask

  task automatic force_state(input logic [3:0] s);
    put(1'b1, 1'b0, s, 1'b0, 1'b0);
    edge_sample();
  endtask

  task automatic print_summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1'b1;
      print_summary();
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0;
    clr_n = 1'b1; ld_n = 1'b1; din = 4'd0; en_p = 1'b1; en_t = 1'b1;
    c_clr_n = 1'b0; c_en = 1'b0;
    #(CLK_PERIOD * 3);
    #1;
    chk("R1 reset state", int'(q), 0);
    chk("R1 reset tc", int'(tc), 0);

    // release while counting enabled: two edges of held zero, then count
    @(negedge clk);
    arst_n = 1'b1;
    edge_sample(); chk("R1 hold edge1", int'(q), 0);
    edge_sample(); chk("R1 hold edge2", int'(q), 0);
    edge_sample(); chk("R1 first count", int'(q), 1);

    // asynchronous assertion mid-cycle
    force_state(4'd7);
    @(negedge clk);
    ld_n = 1'b1; en_p = 1'b0;
    #2 arst_n = 1'b0;
    #1 chk("R1 async clear", int'(q), 0);
    @(negedge clk);
    arst_n = 1'b1;
    edge_sample(); edge_sample();

    // exhaustive sweep: every state x every control combination
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        logic cl, ll, pp, tt;
        logic [3:0] d, exp_q;
        string tag;
        cl = c[3]; ll = c[2]; pp = c[1]; tt = c[0];
        d  = 4'((s * 5 + c + 3) % 16);
        force_state(4'(s));
        put(cl, ll, d, pp, tt);
        #1;
        chk("R6 tc level", int'(tc), (tt && s == 9) ? 1 : 0);
        exp_q = model_next(4'(s), cl, ll, d, pp, tt);
        if (!cl)          tag = "R2 clear";
        else if (!ll)     tag = "R3 load";
        else if (pp && tt) tag = (s > 9) ? "R7 recover map" : "R4 count";
        else              tag = "R5 hold";
        edge_sample();
        chk(tag, int'(q), int'(exp_q));
      end
    end

    // bounded recovery from each illegal code
    for (int s = 10; s < 16; s++) begin
      force_state(4'(s));
      put(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
      edge_sample(); edge_sample();
      chk("R8 legal within two", (q <= 4'd9) ? 1 : 0, 1);
    end

    // full count ring with tc watch
    force_state(4'd0);
    put(1'b1, 1'b1, 4'd0, 1'b1, 1'b1);
    for (int k = 1; k <= 12; k++) begin
      edge_sample();
      chk("R4 ring", int'(q), k % 10);
      chk("R6 tc ring", int'(tc), (k % 10 == 9) ? 1 : 0);
    end

    // two-digit cascade
    @(negedge clk);
    c_clr_n = 1'b0; c_en = 1'b1;
    edge_sample();
    chk("R9 cascade cleared", int'(hi_q) * 10 + int'(lo_q), 0);
    @(negedge clk);
    c_clr_n = 1'b1;
    for (int k = 1; k <= 205; k++) begin
      edge_sample();
      chk("R9 cascade", int'(hi_q) * 10 + int'(lo_q), k % 100);
    end
    chk("R9 high tc at 05", int'(hi_tc), 0);

    done = 1'b1;
    print_summary();
    $finish;
  end
endmodule